// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block resolves a guest-virtual address into a host-physical frame when the translation cache misses. Two stacks of radix tables are involved. Guest tables map guest-virtual to guest-physical addresses, and second-level tables map guest-physical to host-physical addresses. Every guest-physical pointer has to be converted into a host address before it can be used. That covers the guest table root, each pointer read from a guest table, and the final data address. Each conversion is a complete descent through the second-level tables. The walk therefore covers a grid rather than a single path.

A miss request supplies three values: the guest-virtual address, the guest table root (a guest-physical address) and the second-level root (a host-physical address). The walker reads memory one 64-bit word at a time over a request/response port. At the end it pulses `walk_done`. With that pulse it presents either the host frame for the direct guest-virtual to host-physical mapping, or a fault that identifies the table dimension and the level. It also presents the number of memory reads the walk used.

Top module: `gva_hpa_walker`

## Requirements
- R1: `req_ready` is 1 only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until `walk_done`. Request inputs presented while busy have no effect on the result.
- R2: `mem_req_valid` stays asserted with a stable `mem_req_addr` until `mem_req_ready`. No new request is raised while a read is waiting for `mem_rsp_valid`.
- R3: The address of each entry read is the table frame × 4096 + 8 × index. For level L (3 down to 0) the index is bits [12+9L+8 : 12+9L] of the address being translated, so level 3 uses bits [47:39].
- R4: The sequence starts with the guest root, whose bits [11:0] are ignored. A guest-physical pointer is read at each guest level 3, 2, 1 and 0. Each of these is translated by a second-level walk of levels 3 to 0 that starts at the second-level root frame. The guest entry is then read at the resulting host frame.
- R5: The final guest-physical address is the guest level-0 entry frame joined with guest-virtual bits [11:0]. It is translated by one more full second-level walk, and `hpa_frame` is the frame from that walk's level-0 entry.
- R6: A walk with no fault makes exactly 24 reads and reports `access_count` = 24.
- R7: An entry with bit 0 (present) = 0 in the second-level tables ends the walk. The walker reports `walk_fault` = 1, `fault_host` = 1, `fault_level` = that second-level level, and `access_count` = the reads made so far, including the faulting one.
- R8: A present = 0 entry in a guest table ends the walk with `walk_fault` = 1, `fault_host` = 0 and `fault_level` = the guest level.
- R9: `walk_done` is a one-cycle pulse. When `walk_fault` = 0, `hpa_frame` holds entry bits [51:12] of the last read.
- R10: After reset `req_ready` = 1, `mem_req_valid` = 0, `walk_done` = 0 and `access_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_gva | input | 48 | Guest-virtual address to resolve |
| req_groot | input | 52 | Guest table root, guest-physical |
| req_sroot | input | 52 | Second-level table root, host-physical |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Host-physical word address of the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Table entry: bit 0 present, bits [51:12] frame |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Walk ended on a non-present entry |
| fault_host | output | 1 | 1: second-level fault, 0: guest-table fault |
| fault_level | output | 2 | Level of the faulting entry |
| hpa_frame | output | 40 | Host-physical frame of the mapping |
| access_count | output | 5 | Memory reads made by the walk |

## Verification
The checker watches the memory port handshake on every cycle. It checks that requests are held stable and that only one read is ever outstanding. It also checks that `req_ready` stays low during a walk, that `walk_done` lasts one cycle, and that the reported count equals the reads actually issued. Whether each read address is the correct grid position, whether the right frame comes back, and whether faults carry the correct dimension and level can only be shown by the bench. The bench compares each walk against its own model of the two table stacks, with a fault injected at every read position in turn.

// File: rtl/walk_pkg.sv
// Shared types for the nested walker: controller states and the table
// dimension currently being walked. Assumes nothing beyond IEEE 1800-2017.
package walk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_t;

    typedef enum logic {
        DIM_GUEST = 1'b0,
        DIM_HOST  = 1'b1
    } walk_dim_t;
endpackage

// File: rtl/walk_addr_gen.sv
// Entry address composer. Picks the address being translated (the
// guest-virtual address in the guest dimension, the current guest-physical
// address in the second-level dimension) and the level index, and forms
// table frame * page size + entry size * index.
// Assumes table frames are page aligned, so no carry reaches the frame bits.
module walk_addr_gen
    import walk_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PAGE_W = 12,
    parameter int PA_W   = 52,
    parameter int ENT_LG = 3,
    localparam int VA_W  = PAGE_W + IDX_W * LEVELS,
    localparam int FR_W  = PA_W - PAGE_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  walk_dim_t           dim,
    input  logic [LVL_W-1:0]    glvl,
    input  logic [LVL_W-1:0]    slvl,
    input  logic [VA_W-1:0]     gva,
    input  logic [PA_W-1:0]     cur_gpa,
    input  logic [FR_W-1:0]     table_frame,
    output logic [PA_W-1:0]     addr
);
    logic [VA_W-1:0]  src;
    logic [LVL_W-1:0] lvl;
    logic [IDX_W-1:0] idx;
    logic             unused_hi;

    assign unused_hi = ^cur_gpa[PA_W-1:VA_W];

    // Select the source address and level, slice the index, compose address.
    always_comb begin
        src  = (dim == DIM_GUEST) ? gva : cur_gpa[VA_W-1:0];
        lvl  = (dim == DIM_GUEST) ? glvl : slvl;
        idx  = src[PAGE_W + IDX_W * lvl +: IDX_W];
        addr = {table_frame, {PAGE_W{1'b0}}} + PA_W'({idx, {ENT_LG{1'b0}}});
    end
endmodule

// File: rtl/walk_ctrl.sv
// Walk sequencer. Runs a second-level descent for the guest root, then for
// every guest pointer, and finally for the data address, interleaving one
// guest entry read after each intermediate descent. It holds one memory read
// in flight, counts reads, and ends early on a non-present entry.
// Assumes the memory returns exactly one response per accepted read.
module walk_ctrl
    import walk_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PAGE_W = 12,
    parameter int PA_W   = 52,
    parameter int ENT_W  = 64,
    localparam int VA_W      = PAGE_W + IDX_W * LEVELS,
    localparam int FR_W      = PA_W - PAGE_W,
    localparam int LVL_W     = $clog2(LEVELS),
    localparam int MAX_READS = (LEVELS + 1) * (LEVELS + 1) - 1,
    localparam int CNT_W     = $clog2(MAX_READS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_gva,
    input  logic [PA_W-1:0]   req_groot,
    input  logic [PA_W-1:0]   req_sroot,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output walk_dim_t         dim,
    output logic [LVL_W-1:0]  glvl,
    output logic [LVL_W-1:0]  slvl,
    output logic [VA_W-1:0]   gva,
    output logic [PA_W-1:0]   cur_gpa,
    output logic [FR_W-1:0]   table_frame,
    output logic              walk_done,
    output logic              walk_fault,
    output logic              fault_host,
    output logic [LVL_W-1:0]  fault_level,
    output logic [FR_W-1:0]   hpa_frame,
    output logic [CNT_W-1:0]  access_count
);
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(LEVELS - 1);

    walk_state_t      state_q;
    walk_dim_t        dim_q;
    logic [LVL_W-1:0] glvl_q, slvl_q, flvl_q;
    logic [VA_W-1:0]  gva_q;
    logic [PA_W-1:0]  gpa_q;
    logic [FR_W-1:0]  tframe_q, sroot_q, hframe_q;
    logic             final_q, done_q, fault_q, fhost_q;
    logic [CNT_W-1:0] count_q;
    logic             present;
    logic [FR_W-1:0]  ent_frame;
    logic             unused_bits;

    assign present     = mem_rsp_data[0];
    assign ent_frame   = mem_rsp_data[PA_W-1:PAGE_W];
    assign unused_bits = ^{mem_rsp_data[ENT_W-1:PA_W], mem_rsp_data[PAGE_W-1:1],
                           req_groot[PAGE_W-1:0], req_sroot[PAGE_W-1:0]};

    // Walk state machine: accept, issue one read, consume its entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dim_q    <= DIM_HOST;
            glvl_q   <= '0;
            slvl_q   <= '0;
            flvl_q   <= '0;
            gva_q    <= '0;
            gpa_q    <= '0;
            tframe_q <= '0;
            sroot_q  <= '0;
            hframe_q <= '0;
            final_q  <= 1'b0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            fhost_q  <= 1'b0;
            count_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        gva_q    <= req_gva;
                        gpa_q    <= {req_groot[PA_W-1:PAGE_W], {PAGE_W{1'b0}}};
                        sroot_q  <= req_sroot[PA_W-1:PAGE_W];
                        tframe_q <= req_sroot[PA_W-1:PAGE_W];
                        dim_q    <= DIM_HOST;
                        glvl_q   <= LVL_TOP;
                        slvl_q   <= LVL_TOP;
                        final_q  <= 1'b0;
                        count_q  <= '0;
                        state_q  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) begin
                        count_q <= count_q + CNT_W'(1);
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!present) begin
                            done_q   <= 1'b1;
                            fault_q  <= 1'b1;
                            fhost_q  <= (dim_q == DIM_HOST);
                            flvl_q   <= (dim_q == DIM_HOST) ? slvl_q : glvl_q;
                            hframe_q <= '0;
                            state_q  <= ST_IDLE;
                        end else if (dim_q == DIM_HOST) begin
                            if (slvl_q != '0) begin
                                tframe_q <= ent_frame;
                                slvl_q   <= slvl_q - LVL_W'(1);
                                state_q  <= ST_ISSUE;
                            end else if (final_q) begin
                                done_q   <= 1'b1;
                                fault_q  <= 1'b0;
                                fhost_q  <= 1'b0;
                                flvl_q   <= '0;
                                hframe_q <= ent_frame;
                                state_q  <= ST_IDLE;
                            end else begin
                                tframe_q <= ent_frame;
                                dim_q    <= DIM_GUEST;
                                state_q  <= ST_ISSUE;
                            end
                        end else begin
                            tframe_q <= sroot_q;
                            dim_q    <= DIM_HOST;
                            slvl_q   <= LVL_TOP;
                            state_q  <= ST_ISSUE;
                            if (glvl_q == '0) begin
                                gpa_q   <= {ent_frame, gva_q[PAGE_W-1:0]};
                                final_q <= 1'b1;
                            end else begin
                                gpa_q  <= {ent_frame, {PAGE_W{1'b0}}};
                                glvl_q <= glvl_q - LVL_W'(1);
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive outputs from the registered walk state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        dim           = dim_q;
        glvl          = glvl_q;
        slvl          = slvl_q;
        gva           = gva_q;
        cur_gpa       = gpa_q;
        table_frame   = tframe_q;
        walk_done     = done_q;
        walk_fault    = fault_q;
        fault_host    = fhost_q;
        fault_level   = flvl_q;
        hpa_frame     = hframe_q;
        access_count  = count_q;
    end
endmodule

// File: rtl/gva_hpa_walker.sv
// Nested page walker top. Joins the sequencer, which holds all state, to the
// address composer, which turns that state into the entry address of the
// next read. Assumes a memory that accepts single-word reads and answers
// each one in order.
module gva_hpa_walker #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PAGE_W = 12,
    parameter int PA_W   = 52,
    parameter int ENT_W  = 64,
    localparam int VA_W      = PAGE_W + IDX_W * LEVELS,
    localparam int FR_W      = PA_W - PAGE_W,
    localparam int LVL_W     = $clog2(LEVELS),
    localparam int MAX_READS = (LEVELS + 1) * (LEVELS + 1) - 1,
    localparam int CNT_W     = $clog2(MAX_READS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_gva,
    input  logic [PA_W-1:0]   req_groot,
    input  logic [PA_W-1:0]   req_sroot,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              walk_done,
    output logic              walk_fault,
    output logic              fault_host,
    output logic [LVL_W-1:0]  fault_level,
    output logic [FR_W-1:0]   hpa_frame,
    output logic [CNT_W-1:0]  access_count
);
    walk_pkg::walk_dim_t dim;
    logic [LVL_W-1:0]    glvl, slvl;
    logic [VA_W-1:0]     gva;
    logic [PA_W-1:0]     cur_gpa;
    logic [FR_W-1:0]     table_frame;

    walk_ctrl #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .PAGE_W (PAGE_W),
        .PA_W   (PA_W),
        .ENT_W  (ENT_W)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_gva       (req_gva),
        .req_groot     (req_groot),
        .req_sroot     (req_sroot),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .dim           (dim),
        .glvl          (glvl),
        .slvl          (slvl),
        .gva           (gva),
        .cur_gpa       (cur_gpa),
        .table_frame   (table_frame),
        .walk_done     (walk_done),
        .walk_fault    (walk_fault),
        .fault_host    (fault_host),
        .fault_level   (fault_level),
        .hpa_frame     (hpa_frame),
        .access_count  (access_count)
    );

    walk_addr_gen #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .PAGE_W (PAGE_W),
        .PA_W   (PA_W),
        .ENT_LG ($clog2(ENT_W / 8))
    ) i_addr (
        .dim         (dim),
        .glvl        (glvl),
        .slvl        (slvl),
        .gva         (gva),
        .cur_gpa     (cur_gpa),
        .table_frame (table_frame),
        .addr        (mem_req_addr)
    );
endmodule

// File: rtl/walk_checker.sv
// Protocol and bookkeeping checker for the nested walker. Tracks the
// outstanding read, the busy interval and the reads issued per walk, and
// compares them with the walker's ports. Attached by bind below.
module walk_checker #(
    parameter int PA_W      = 52,
    parameter int CNT_W     = 5,
    parameter int MAX_READS = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             walk_done,
    input logic             walk_fault,
    input logic [CNT_W-1:0] access_count
);
    logic             outstanding;
    logic             busy;
    logic [CNT_W-1:0] reads_seen;

    // Track read in flight, walk in progress and reads issued this walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            busy        <= 1'b0;
            reads_seen  <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
            else if (mem_rsp_valid)             outstanding <= 1'b0;
            if (req_valid && req_ready) busy <= 1'b1;
            else if (walk_done)         busy <= 1'b0;
            if (req_valid && req_ready)              reads_seen <= '0;
            else if (mem_req_valid && mem_req_ready) reads_seen <= reads_seen + CNT_W'(1);
        end
    end

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !walk_done) |-> !req_ready);

    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    a_r6_full_walk_count: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && !walk_fault) |-> (access_count == CNT_W'(MAX_READS)));

    a_r7_count_matches_reads: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (access_count == reads_seen));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);
endmodule

bind gva_hpa_walker walk_checker #(
    .PA_W      (PA_W),
    .CNT_W     (CNT_W),
    .MAX_READS (MAX_READS)
) i_walk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .walk_done     (walk_done),
    .walk_fault    (walk_fault),
    .access_count  (access_count)
);

// File: tb/test_gva_hpa_walker.sv
`timescale 1ns/1ps
module test_gva_hpa_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_gva = '0;
    logic [51:0] req_groot = '0;
    logic [51:0] req_sroot = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        walk_done, walk_fault, fault_host;
    logic [1:0]  fault_level;
    logic [39:0] hpa_frame;
    logic [4:0]  access_count;

    int checks = 0;
    int errors = 0;

    // Expected walk, built by the bench model
    logic [51:0] exp_addr [0:23];
    int          exp_len;
    bit          e_fault, e_host;
    int          e_lvl;
    logic [39:0] e_frame;
    logic [63:0] salt = 64'h0;
    int          fault_sel = -1;
    int          rd_idx = 0;

    always #4 clk = ~clk;

    gva_hpa_walker i_gva_hpa_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_gva(req_gva), .req_groot(req_groot), .req_sroot(req_sroot),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .walk_fault(walk_fault),
        .fault_host(fault_host), .fault_level(fault_level), .hpa_frame(hpa_frame),
        .access_count(access_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Contents of the table word at a host address (frame part)
    function automatic logic [39:0] frame_of(input logic [51:0] a);
        logic [63:0] h;
        h = 64'(a) * 64'h9E3779B97F4A7C15 + salt;
        return h[63:24];
    endfunction

    function automatic logic [51:0] entry_addr(input logic [39:0] base, input logic [47:0] src, input int lvl);
        return {base, 12'h000} + 52'(src[12 + 9 * lvl +: 9]) * 52'd8;
    endfunction

    // Reference grid walk: R3, R4, R5, R7, R8
    task automatic build_expected(input logic [47:0] gva, input logic [51:0] groot,
                                  input logic [51:0] sroot, input int fsel);
        logic [39:0] base;
        logic [51:0] gpa, a;
        int n;
        bit stop;
        n = 0; stop = 0; e_fault = 0; e_host = 0; e_lvl = 0; e_frame = '0;
        gpa = {groot[51:12], 12'h000};
        for (int t = 0; t <= 4 && !stop; t++) begin
            base = sroot[51:12];
            for (int s = 3; s >= 0 && !stop; s--) begin
                a = entry_addr(base, gpa[47:0], s);
                exp_addr[n] = a;
                if (n == fsel) begin stop = 1; e_fault = 1; e_host = 1; e_lvl = s; end
                n++;
                base = frame_of(a);
            end
            if (!stop) begin
                if (t == 4) e_frame = base;
                else begin
                    a = entry_addr(base, gva, 3 - t);
                    exp_addr[n] = a;
                    if (n == fsel) begin stop = 1; e_fault = 1; e_host = 0; e_lvl = 3 - t; end
                    n++;
                    gpa = (t == 3) ? {frame_of(a), gva[11:0]} : {frame_of(a), 12'h000};
                end
            end
        end
        exp_len = n;
    endtask

    // Memory responder: random ready, random latency, checks addresses
    initial begin : responder
        logic        pend;
        logic [63:0] pend_data;
        int          dly;
        pend = 0; pend_data = '0; dly = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_data;
                    pend = 0;
                end else dly--;
            end
            mem_req_ready = ($urandom_range(0, 3) != 0);
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (rd_idx < exp_len) begin
                    chk(mem_req_addr == exp_addr[rd_idx], "R3/R4 read address", mem_req_addr, exp_addr[rd_idx]);
                    pend_data = {12'h000, frame_of(exp_addr[rd_idx]), 11'h000, (rd_idx != fault_sel)};
                end else begin
                    chk(1'b0, "R6 extra read", 64'(rd_idx), 64'(exp_len));
                    pend_data = 64'h1;
                end
                rd_idx++;
                pend = 1;
                dly = $urandom_range(0, 2);
            end
        end
    end

    task automatic run_walk(input logic [47:0] gva, input logic [51:0] groot,
                            input logic [51:0] sroot, input int fsel, input bit disturb);
        salt = {$urandom, $urandom};
        build_expected(gva, groot, sroot, fsel);
        fault_sel = fsel;
        rd_idx = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_gva = gva; req_groot = groot; req_sroot = sroot;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
        if (disturb) begin
            req_valid = 1'b1; req_gva = ~gva; req_groot = ~groot; req_sroot = ~sroot;
        end
        while (!walk_done) @(negedge clk);
        req_valid = 1'b0;
        chk(walk_fault == e_fault, "R7/R8 fault flag", 64'(walk_fault), 64'(e_fault));
        if (e_fault) begin
            chk(fault_host == e_host, e_host ? "R7 fault dimension" : "R8 fault dimension", 64'(fault_host), 64'(e_host));
            chk(fault_level == 2'(e_lvl), e_host ? "R7 fault level" : "R8 fault level", 64'(fault_level), 64'(e_lvl));
            chk(access_count == 5'(exp_len), "R7 reads before fault", 64'(access_count), 64'(exp_len));
        end else begin
            chk(hpa_frame == e_frame, disturb ? "R1 busy input ignored, R5 frame" : "R5/R9 host frame",
                64'(hpa_frame), 64'(e_frame));
            chk(access_count == 5'd24, "R6 full walk count", 64'(access_count), 64'd24);
        end
        chk(rd_idx == exp_len, "R2 reads issued", 64'(rd_idx), 64'(exp_len));
        @(negedge clk);
        chk(walk_done == 1'b0, "R9 done single pulse", 64'(walk_done), 64'd0);
        chk(req_ready == 1'b1, "R1 ready after done", 64'(req_ready), 64'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        exp_len = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R10 no read in reset", 64'(mem_req_valid), 64'd0);
        chk(walk_done == 1'b0, "R10 no done in reset", 64'(walk_done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(access_count == 5'd0, "R10 count after reset", 64'(access_count), 64'd0);
        chk(mem_req_valid == 1'b0, "R10 idle after reset", 64'(mem_req_valid), 64'd0);
        // Directed full walks: extreme indices, R6 and R5
        run_walk(48'hFFFF_FFFF_FFFF, 52'hF_FFFF_FFFF_FFFF, 52'hF_FFFF_FFFF_FFFF, -1, 0);
        run_walk(48'h0, 52'h0, 52'h0, -1, 0);
        run_walk(48'h8040_2010_0ABC, 52'h1_2345_6789_ACDE, 52'h9_8765_4321_0FFF, -1, 1);
        // Fault injected at every read position: R7 and R8
        for (int k = 0; k < 24; k++)
            run_walk({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, k, 0);
        // Random full walks, some with busy-time request noise: R1, R4
        for (int i = 0; i < 40; i++)
            run_walk({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                     -1, ($urandom_range(0, 1) == 1));
        // Random faulting walks
        for (int i = 0; i < 12; i++)
            run_walk({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                     $urandom_range(0, 23), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule